// File: doc/BRIEF.md
# Four-Channel Interval Timer Bank

The block is a bank of independent down-counting interval timers that software controls through a small memory-mapped register bus. The bus has a select, a write enable, an address, write data, combinational read data and a ready flag. Each channel owns a 64-byte register window: channel n answers at byte addresses n×0x40 through n×0x40+0x3F. In that window software sets a load value, picks a run mode, starts and stops the counter, forces a reload, reads the live count, masks the channel's interrupt line and acknowledges an expiry.

A channel counts down once per clock while it is enabled. When the count reaches zero, the channel latches a pending flag. In continuous mode the channel then reloads from its load value on the next clock. In single mode the count stays at zero. Each channel drives its own interrupt output, which is the pending flag gated by the channel's mask. Every window also shows a status word that carries the pending flags of all channels. An acknowledge runs through a fixed busy window. During that window a new acknowledge is refused, and the pending flag drops when the window closes.

The channel count, the counter width, the bus width, the address width and the length of the acknowledge window are all parameters.

Top module: `mtimer_bank`

## Requirements
- R1: After reset, all channel registers, counters, pending flags and acknowledge state are 0, every irq bit is 0, and every mapped register reads 0.
- R2: A byte address selects channel addr[7:6] and register offset addr[5:0]. An access to one channel's window never changes or returns another channel's registers.
- R3: Offset 0x00 in any window is read-only. Bit n of its value is the pending flag of channel n, and writes to it have no effect.
- R4: Offset 0x10 bit 0 enables the counter. While enabled, the count drops by one every clock. While disabled, the count holds. A write of 1 to this bit while the channel is disabled copies the load value into the counter.
- R5: When offset 0x04 bit 0 is 0 (continuous), the count runs from the load value L down to 0. The pending flag is set on the clock at which the count becomes 0, and L is reloaded on the next clock, so the period is L+1 clocks.
- R6: When offset 0x04 bit 0 is 1 (single), reaching 0 sets the pending flag and the count then stays at 0 while the channel remains enabled.
- R7: A write of any data to offset 0x14 copies the load value held at offset 0x08 into the counter, and that write takes priority over counting.
- R8: Offset 0x18 returns the live counter value, and offset 0x08 returns the load value.
- R9: At offset 0x20, bit 0 reads the pending flag and bit 1 reads the acknowledge-busy flag. A write with bit 0 = 1 while not busy makes bit 1 read 1 for exactly 4 clocks, after which the pending flag clears. A write with bit 0 = 0 has no effect.
- R10: A write with bit 0 = 1 to offset 0x20 while the busy flag is set is ignored and does not extend the busy window.
- R11: irq[n] is 1 exactly when channel n's pending flag is 1 and offset 0x24 bit 0 (mask, 1 = masked) is 0.
- R12: Unmapped offsets read 0, and bus_ready equals bus_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address: channel window and register offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data, 0 when not selected |
| bus_ready | output | 1 | Access completes in the current cycle |
| irq | output | NUM_CH (4) | Per-channel interrupt lines |

## Verification
The main counting function is tried with a continuous channel that wraps several times, a single-shot channel that is left idle well past expiry, a forced reload that carries nonsense data in the middle of a count, and a stop followed by a restart. Sampling the live count at fixed clock offsets after each start separates a period of L from a period of L+1. It also separates a held count from a wrapped count, and a restart that reloads from one that resumes. The acknowledge path is tried with a second acknowledge inside the busy window and with a zero write. The status word and the interrupt lines are read while neighbouring channels are masked or pending, which shows whether window decode and gating stay per channel.

// File: rtl/mtimer_pkg.sv
`timescale 1ns/1ps
package mtimer_pkg;

   // Width of one channel's byte window
   localparam int WIN_BITS = 6;

   // Register offsets inside a window
   localparam logic [WIN_BITS-1:0] OFF_STATUS = 6'h00;
   localparam logic [WIN_BITS-1:0] OFF_CTRL   = 6'h04;
   localparam logic [WIN_BITS-1:0] OFF_LOAD   = 6'h08;
   localparam logic [WIN_BITS-1:0] OFF_ENABLE = 6'h10;
   localparam logic [WIN_BITS-1:0] OFF_RELOAD = 6'h14;
   localparam logic [WIN_BITS-1:0] OFF_VALUE  = 6'h18;
   localparam logic [WIN_BITS-1:0] OFF_ACK    = 6'h20;
   localparam logic [WIN_BITS-1:0] OFF_MASK   = 6'h24;

   typedef enum logic {
      MODE_CONT   = 1'b0,
      MODE_SINGLE = 1'b1
   } run_mode_t;

   // One-hot register selection produced by the decoder
   typedef struct packed {
      logic status;
      logic ctrl;
      logic load;
      logic enable;
      logic reload;
      logic value;
      logic ack;
      logic mask;
   } reg_hit_t;

endpackage

// File: rtl/mtimer_decode.sv
`timescale 1ns/1ps
module mtimer_decode
   import mtimer_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 8
) (
   input  logic              bus_sel,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [NUM_CH-1:0] ch_hit,
   output reg_hit_t          hit
);

   localparam int UW = ADDR_W - WIN_BITS;

   logic [WIN_BITS-1:0] off;
   logic [UW-1:0]       win;

   assign off = bus_addr[WIN_BITS-1:0];
   assign win = bus_addr[ADDR_W-1:WIN_BITS];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_win
      assign ch_hit[i] = bus_sel && (win == UW'(i));
   end

   always_comb begin
      hit        = '0;
      hit.status = (off == OFF_STATUS);
      hit.ctrl   = (off == OFF_CTRL);
      hit.load   = (off == OFF_LOAD);
      hit.enable = (off == OFF_ENABLE);
      hit.reload = (off == OFF_RELOAD);
      hit.value  = (off == OFF_VALUE);
      hit.ack    = (off == OFF_ACK);
      hit.mask   = (off == OFF_MASK);
   end

endmodule

// File: rtl/mtimer_ackhs.sv
`timescale 1ns/1ps
module mtimer_ackhs #(
   parameter int BUSY_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic busy,
   output logic done
);

   localparam int BW = $clog2(BUSY_CYC + 1);

   if (BUSY_CYC == 1) begin : g_flop
      logic b_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    b_q <= 1'b0;
         else if (b_q)  b_q <= 1'b0;
         else           b_q <= req;
      end

      assign busy = b_q;
      assign done = b_q;
   end else begin : g_cnt
      logic [BW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               cnt_q <= '0;
         else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
         else if (req)             cnt_q <= BW'(BUSY_CYC);
      end

      assign busy = (cnt_q != '0);
      assign done = (cnt_q == BW'(1));

      // R10: a request inside the window does not restart it
      p_busy_ignore_r10 : assert property (@(posedge clk) disable iff (!rst_n)
         (busy && req) |=> (cnt_q == $past(cnt_q) - 1'b1));
   end

endmodule

// File: rtl/mtimer_chan.sv
`timescale 1ns/1ps
module mtimer_chan
   import mtimer_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int DATA_W   = 32,
   parameter int BUSY_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  reg_hit_t          hit,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              pending,
   output logic              irq_o
);

   run_mode_t          mode_q;
   logic [CNT_W-1:0]   load_q;
   logic [CNT_W-1:0]   count_q;
   logic               enable_q;
   logic               mask_q;
   logic               pending_q;
   logic               force_load;
   logic               expire;
   logic               ack_req;
   logic               ack_busy;
   logic               ack_done;

   // Software-visible configuration
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_CONT;
         load_q   <= '0;
         enable_q <= 1'b0;
         mask_q   <= 1'b0;
      end else if (wr) begin
         if (hit.ctrl)   mode_q   <= run_mode_t'(wdata[0]);
         if (hit.load)   load_q   <= wdata[CNT_W-1:0];
         if (hit.enable) enable_q <= wdata[0];
         if (hit.mask)   mask_q   <= wdata[0];
      end
   end

   // Reload on a reload write or on a start from the stopped state
   assign force_load = wr && (hit.reload || (hit.enable && wdata[0] && !enable_q));
   assign expire     = enable_q && !force_load && (count_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (force_load) begin
         count_q <= load_q;
      end else if (enable_q) begin
         if (count_q != '0)           count_q <= count_q - 1'b1;
         else if (mode_q == MODE_CONT) count_q <= load_q;
      end
   end

   assign ack_req = wr && hit.ack && wdata[0];

   mtimer_ackhs #(.BUSY_CYC(BUSY_CYC)) u_ack (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (ack_req),
      .busy (ack_busy),
      .done (ack_done)
   );

   // A new expiry wins over a completing acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pending_q <= 1'b0;
      else if (expire)   pending_q <= 1'b1;
      else if (ack_done) pending_q <= 1'b0;
   end

   assign pending = pending_q;
   assign irq_o   = pending_q && !mask_q;

   always_comb begin
      rdata = '0;
      unique case (1'b1)
         hit.status: rdata = '0;
         hit.ctrl:   rdata[0] = mode_q;
         hit.load:   rdata = DATA_W'(load_q);
         hit.enable: rdata[0] = enable_q;
         hit.value:  rdata = DATA_W'(count_q);
         hit.ack:    rdata[1:0] = {ack_busy, pending_q};
         hit.mask:   rdata[0] = mask_q;
         default:    rdata = '0;
      endcase
   end

   // R4: one step down per clock while enabled
   p_step_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable_q && count_q != '0 && !wr) |=> (count_q == $past(count_q) - 1'b1));

   // R4: a stopped counter holds
   p_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!enable_q && !wr) |=> $stable(count_q));

   // R5: reaching zero raises the pending flag
   p_expire_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable_q && count_q == CNT_W'(1) && !wr) |=> pending_q);

   // R5: continuous mode reloads from zero
   p_wrap_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable_q && mode_q == MODE_CONT && count_q == '0 && !wr) |=> (count_q == $past(load_q)));

   // R6: single mode parks at zero
   p_park_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable_q && mode_q == MODE_SINGLE && count_q == '0 && !wr) |=> (count_q == '0));

   // R9: end of the busy window leaves nothing pending unless a new expiry came
   p_ack_drop_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ack_busy) && !$past(expire)) |-> !pending_q);

endmodule

// File: rtl/mtimer_bank.sv
`timescale 1ns/1ps
module mtimer_bank
   import mtimer_pkg::*;
#(
   parameter int NUM_CH       = 4,
   parameter int CNT_W        = 32,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 8,
   parameter int CLR_BUSY_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ready,
   output logic [NUM_CH-1:0] irq
);

   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1)                 begin : g_chk_ch   $error("NUM_CH must be at least 1"); end
   if (ADDR_W < WIN_BITS + CH_W)   begin : g_chk_addr $error("ADDR_W too small for all windows"); end
   if (CNT_W > DATA_W || CNT_W < 2) begin : g_chk_cnt $error("CNT_W must be 2..DATA_W"); end
   if (DATA_W < NUM_CH || DATA_W < 2) begin : g_chk_dw $error("DATA_W too small for status"); end
   if (CLR_BUSY_CYC < 1)           begin : g_chk_busy $error("CLR_BUSY_CYC must be at least 1"); end

   logic [NUM_CH-1:0] ch_hit;
   reg_hit_t          hit;
   logic [NUM_CH-1:0] pend_vec;
   logic [DATA_W-1:0] ch_rd [NUM_CH];

   mtimer_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .bus_sel (bus_sel),
      .bus_addr(bus_addr),
      .ch_hit  (ch_hit),
      .hit     (hit)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      mtimer_chan #(
         .CNT_W   (CNT_W),
         .DATA_W  (DATA_W),
         .BUSY_CYC(CLR_BUSY_CYC)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr     (bus_wr && ch_hit[i]),
         .hit    (hit),
         .wdata  (bus_wdata),
         .rdata  (ch_rd[i]),
         .pending(pend_vec[i]),
         .irq_o  (irq[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_hit[i]) bus_rdata = bus_rdata | ch_rd[i];
      end
      if ((|ch_hit) && hit.status) bus_rdata = DATA_W'(pend_vec);
   end

   assign bus_ready = bus_sel;

   // R2: reads outside any selected window return zero
   p_idle_zero_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (ch_hit == '0) |-> (bus_rdata == '0));

endmodule

// File: tb/mtimer_bank_tb.sv
`timescale 1ns/1ps
module mtimer_bank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic [3:0]  irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   mtimer_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .irq(irq)
   );

   localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_I = 2'd2, OP_Q = 2'd3;
   localparam int NV = 28;
   // {op, addr, data or expected, requirement}
   localparam logic [45:0] VEC [NV] = '{
      {OP_W, 8'h48, 32'd5,       4'd5},  // R5 load ch1
      {OP_W, 8'h44, 32'd0,       4'd5},  // R5 continuous
      {OP_W, 8'h50, 32'd1,       4'd4},  // R4 start
      {OP_R, 8'h58, 32'd5,       4'd4},  // R4 k0
      {OP_R, 8'h58, 32'd4,       4'd4},  // R4 k1
      {OP_I, 8'h00, 32'd0,       4'd4},  // k2
      {OP_R, 8'h58, 32'd2,       4'd8},  // R8 k3
      {OP_R, 8'h00, 32'd0,       4'd3},  // R3 k4 nothing pending yet
      {OP_R, 8'h58, 32'd0,       4'd5},  // R5 k5 zero reached
      {OP_R, 8'h40, 32'd2,       4'd3},  // R3 k6 ch1 pending
      {OP_R, 8'h58, 32'd4,       4'd5},  // R5 k7 after wrap
      {OP_R, 8'h60, 32'd1,       4'd9},  // R9 k8
      {OP_R, 8'h64, 32'd0,       4'd11}, // R11 k9
      {OP_Q, 8'h00, 32'd2,       4'd11}, // R11 k10
      {OP_W, 8'h64, 32'd1,       4'd11}, // R11 mask
      {OP_Q, 8'h00, 32'd0,       4'd11}, // R11 masked
      {OP_W, 8'h64, 32'd0,       4'd11}, // R11 unmask
      {OP_Q, 8'h00, 32'd2,       4'd11}, // R11
      {OP_W, 8'h54, 32'hDEAD,    4'd7},  // R7 reload with junk data
      {OP_R, 8'h58, 32'd5,       4'd7},  // R7
      {OP_R, 8'h58, 32'd4,       4'd7},  // R7
      {OP_R, 8'h18, 32'd0,       4'd2},  // R2 ch0 untouched
      {OP_R, 8'h08, 32'd0,       4'd2},  // R2
      {OP_R, 8'h4C, 32'd0,       4'd12}, // R12 unmapped
      {OP_R, 8'h7C, 32'd0,       4'd12}, // R12 unmapped
      {OP_W, 8'h40, 32'hF,       4'd3},  // R3 write to status
      {OP_R, 8'h40, 32'd2,       4'd3},  // R3 unchanged
      {OP_W, 8'h50, 32'd0,       4'd4}   // R4 stop ch1
   };

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // All bus tasks start at a falling edge and take one clock
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      check(req, $sformatf("read 0x%02h", a), bus_rdata, exp);
      bus_sel = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk_irq(input int req, input logic [3:0] exp);
      #1;
      check(req, "irq", {28'd0, irq}, {28'd0, exp});
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      #1 check(1, "irq in reset", {28'd0, irq}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(1, 8'h18, 32'd0);
      rd(1, 8'h24, 32'd0);
      bus_sel = 1'b1; bus_addr = 8'h04; #1;
      check(12, "bus_ready with select", {31'd0, bus_ready}, 32'd1); // R12
      bus_sel = 1'b0; #1;
      check(12, "bus_ready idle", {31'd0, bus_ready}, 32'd0);
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         case (VEC[i][45:44])
            OP_W: wr(VEC[i][43:36], VEC[i][35:4]);
            OP_R: rd(int'(VEC[i][3:0]), VEC[i][43:36], VEC[i][35:4]);
            OP_I: idle(1);
            default: chk_irq(int'(VEC[i][3:0]), VEC[i][7:4]);
         endcase
      end

      // R9 / R10: acknowledge handshake on ch1
      wr(8'h60, 32'd1);
      rd(9, 8'h60, 32'd3);
      wr(8'h60, 32'd1);          // R10 ignored while busy
      rd(9, 8'h60, 32'd3);
      rd(9, 8'h60, 32'd3);
      rd(10, 8'h60, 32'd0);      // R10 window not extended
      chk_irq(11, 4'b0000);

      // R6: single-shot ch2
      wr(8'h88, 32'd3);
      wr(8'h84, 32'd1);
      wr(8'h90, 32'd1);
      rd(6, 8'h98, 32'd3);
      idle(2);
      rd(6, 8'h98, 32'd0);
      idle(5);
      rd(6, 8'h98, 32'd0);
      rd(3, 8'h80, 32'd4);
      rd(9, 8'hA0, 32'd1);
      wr(8'hA0, 32'd0);          // R9 zero write has no effect
      rd(9, 8'hA0, 32'd1);
      chk_irq(11, 4'b0100);
      // R4: restart reloads, stop holds
      wr(8'h90, 32'd0);
      wr(8'h90, 32'd1);
      rd(4, 8'h98, 32'd3);
      wr(8'h90, 32'd0);
      idle(3);
      rd(4, 8'h98, 32'd1);

      // R11: ch3 masked before its expiry
      wr(8'hE4, 32'd1);
      wr(8'hC8, 32'd2);
      wr(8'hC4, 32'd1);
      wr(8'hD0, 32'd1);
      idle(4);
      chk_irq(11, 4'b0100);
      rd(3, 8'hC0, 32'hC);
      wr(8'hE4, 32'd0);
      chk_irq(11, 4'b1100);

      // R1: reset in the middle of activity
      rst_n = 1'b0;
      @(negedge clk);
      #1 check(1, "irq after reset", {28'd0, irq}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(1, 8'h80, 32'd0);
      rd(1, 8'h98, 32'd0);
      rd(1, 8'h88, 32'd0);
      rd(1, 8'hE0, 32'd0);

      summary();
   end

endmodule